// File: doc/BRIEF.md
# Serial Receive Error Flag Unit

This block keeps the error flags of a serial receiver and raises one shared error interrupt. A separate receiver datapath gives it one pulse per detected problem: noise on any sampled bit of a character (start, data or stop bits, break characters included), a low level where the stop bit belongs, and a parity mismatch. Each pulse sets a sticky flag. Each flag has its own interrupt enable. A registered request goes high while any enabled flag is set.

Software clears the flags in two steps. It reads the status register while a flag is set, which arms that flag. A later access to the data register then clears every armed flag. A debug-halt input works together with a clear-permit control bit. While the core is halted and the bit is 0, which is its reset value, both steps are ignored. While the core is halted and the bit is 1, clearing works as normal. A module-enable input holds the whole unit at zero when it is low.

Top module: `uart_rx_err_status`

## Requirements
- R1: A high `err_ev[i]` while `mod_en` is 1 sets `err_flag[i]` at the next clock edge. Bit 0 is noise, bit 1 is framing and bit 2 is parity.
- R2: A `stat_rd` pulse while `err_flag[i]` is set arms that flag. A later `data_acc` pulse clears every armed flag at its edge and leaves unarmed flags set.
- R3: A `data_acc` with no earlier arming read leaves the flags unchanged. A `stat_rd` and a `data_acc` in the same cycle arm nothing.
- R4: An event on a flag in the same cycle as a clearing `data_acc` wins, and the flag stays set.
- R5: An event on an armed flag before the `data_acc` cancels its arming, so that access leaves the flag set.
- R6: While `dbg_halt` is 1 and `halt_clr_ok` is 0, `stat_rd` and `data_acc` have no effect on the flags or on the arming.
- R7: While `dbg_halt` is 1 and `halt_clr_ok` is 1, the two-step clear works. A flag cleared this way stays clear after the halt ends.
- R8: A status read made during a protected halt does not arm, so a `data_acc` after the halt leaves the flag set.
- R9: `err_irq` equals the OR over i of (`err_flag[i]` AND `irq_en[i]`), delayed by one clock.
- R10: While `mod_en` is 0, the flags and the arming are zero from the next edge on, and events are ignored. `err_irq` follows one cycle later.
- R11: After reset, all flags, all arming and `err_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low holds state at zero |
| err_ev | input | NFLAG | Error event pulses (0 noise, 1 framing, 2 parity) |
| irq_en | input | NFLAG | Per-flag interrupt enables |
| dbg_halt | input | 1 | Core debug halt active |
| halt_clr_ok | input | 1 | Permits clearing during halt when 1 |
| stat_rd | input | 1 | Status register read strobe |
| data_acc | input | 1 | Data register access strobe |
| err_flag | output | NFLAG | Sticky error flags |
| err_irq | output | 1 | Registered combined error request |

## Verification
The bench builds the block with `NFLAG` = 3, the default. With that value all three flag positions, and every mix of enables, can be driven at random in one run. Directed sequences cover each clear-ordering case: a read and an access in the same cycle, an event between the two steps, an event on the clearing cycle, and reads made during protected and permitted halts. Random stimulus then weaves halts, disables and enables together, and a bench model checks the outputs every cycle.

// File: rtl/uart_rx_err_status.sv
module uart_rx_err_status #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic [NFLAG-1:0] err_ev,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             dbg_halt,
  input  logic             halt_clr_ok,
  input  logic             stat_rd,
  input  logic             data_acc,
  output logic [NFLAG-1:0] err_flag,
  output logic             err_irq
);

  logic             clr_win;
  logic             rd_ok;
  logic             acc_ok;
  logic [NFLAG-1:0] armed;

  assign clr_win = !dbg_halt || halt_clr_ok;
  assign rd_ok   = stat_rd && clr_win;
  assign acc_ok  = data_acc && clr_win;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        err_flag[i] <= 1'b0;
        armed[i]    <= 1'b0;
      end else if (!mod_en) begin
        err_flag[i] <= 1'b0;
        armed[i]    <= 1'b0;
      end else if (err_ev[i]) begin
        err_flag[i] <= 1'b1;
        armed[i]    <= 1'b0;
      end else if (acc_ok) begin
        if (armed[i]) err_flag[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else if (rd_ok && err_flag[i]) begin
        armed[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_irq <= 1'b0;
    else        err_irq <= |(err_flag & irq_en);
  end

endmodule

// File: rtl/uart_rx_err_status_chk.sv
module uart_rx_err_status_chk #(
  parameter int NFLAG = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en,
  input logic [NFLAG-1:0] err_ev,
  input logic [NFLAG-1:0] irq_en,
  input logic             dbg_halt,
  input logic             halt_clr_ok,
  input logic             stat_rd,
  input logic             data_acc,
  input logic [NFLAG-1:0] err_flag,
  input logic             err_irq
);

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && |err_ev) |=> ((err_flag & $past(err_ev)) == $past(err_ev))); // R1

  AST_CLEAR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !data_acc) |=> ((~err_flag & $past(err_flag)) == '0)); // R2

  AST_HALT_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && dbg_halt && !halt_clr_ok && err_ev == '0) |=> $stable(err_flag)); // R6

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_irq == |($past(err_flag) & $past(irq_en)))); // R9

  AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (err_flag == '0)); // R10

endmodule

bind uart_rx_err_status uart_rx_err_status_chk #(.NFLAG(NFLAG)) u_chk (.*);

// File: tb/test_uart_rx_err_status.sv
module test_uart_rx_err_status;
  localparam int NF = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mod_en = 1'b0;
  logic [NF-1:0] err_ev = '0;
  logic [NF-1:0] irq_en = '0;
  logic          dbg_halt = 1'b0;
  logic          halt_clr_ok = 1'b0;
  logic          stat_rd = 1'b0;
  logic          data_acc = 1'b0;
  logic [NF-1:0] err_flag;
  logic          err_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [NF-1:0] mf = '0;
  logic [NF-1:0] ma = '0;
  logic          mi = 1'b0;

  always #10 clk = ~clk;

  uart_rx_err_status #(.NFLAG(NF)) i_uart_rx_err_status (.*);

  function automatic logic [2*NF:0] model_next(logic [NF-1:0] f, logic [NF-1:0] a);
    logic [NF-1:0] nf;
    logic [NF-1:0] na;
    logic win;
    nf = f;
    na = a;
    win = !dbg_halt || halt_clr_ok;
    for (int i = 0; i < NF; i++) begin
      if (!mod_en) begin
        nf[i] = 1'b0; na[i] = 1'b0;
      end else if (err_ev[i]) begin
        nf[i] = 1'b1; na[i] = 1'b0;
      end else if (data_acc && win) begin
        if (a[i]) nf[i] = 1'b0;
        na[i] = 1'b0;
      end else if (stat_rd && win && f[i]) begin
        na[i] = 1'b1;
      end
    end
    return {|(f & irq_en), nf, na};
  endfunction

  task automatic tick();
    logic [2*NF:0] nx;
    nx = model_next(mf, ma);
    @(posedge clk);
    #2;
    {mi, mf, ma} = nx;
  endtask

  task automatic chk(string rq, logic [NF:0] act, logic [NF:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic clear_in();
    err_ev = '0; stat_rd = 1'b0; data_acc = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'h1d5e_a0c3));
    repeat (3) @(posedge clk);
    #2;
    chk("R11", {err_irq, err_flag}, 4'b0000);
    rst_n = 1'b1;
    mod_en = 1'b1;
    tick();
    chk("R11", {err_irq, err_flag}, 4'b0000);

    err_ev = 3'b001; tick(); clear_in();
    chk("R1", {1'b0, err_flag}, 4'b0001);
    err_ev = 3'b110; tick(); clear_in();
    chk("R1", {1'b0, err_flag}, 4'b0111);
    irq_en = 3'b100; tick();
    chk("R9", {err_irq, err_flag}, 4'b1111);

    data_acc = 1'b1; tick(); clear_in();
    chk("R3", {1'b0, err_flag}, 4'b0111);
    stat_rd = 1'b1; data_acc = 1'b1; tick(); clear_in();
    data_acc = 1'b1; tick(); clear_in();
    chk("R3", {1'b0, err_flag}, 4'b0111);

    stat_rd = 1'b1; tick(); clear_in();
    err_ev = 3'b010; tick(); clear_in();
    data_acc = 1'b1; tick(); clear_in();
    chk("R2 R5", {1'b0, err_flag}, 4'b0010);
    tick();
    chk("R9", {err_irq, err_flag}, 4'b0010);

    stat_rd = 1'b1; tick(); clear_in();
    data_acc = 1'b1; err_ev = 3'b010; tick(); clear_in();
    chk("R4", {1'b0, err_flag}, 4'b0010);

    dbg_halt = 1'b1; halt_clr_ok = 1'b0;
    stat_rd = 1'b1; tick(); clear_in();
    data_acc = 1'b1; tick(); clear_in();
    chk("R6", {1'b0, err_flag}, 4'b0010);
    dbg_halt = 1'b0;
    data_acc = 1'b1; tick(); clear_in();
    chk("R8", {1'b0, err_flag}, 4'b0010);

    dbg_halt = 1'b1; halt_clr_ok = 1'b1;
    stat_rd = 1'b1; tick(); clear_in();
    data_acc = 1'b1; tick(); clear_in();
    chk("R7", {1'b0, err_flag}, 4'b0000);
    dbg_halt = 1'b0; halt_clr_ok = 1'b0;
    tick(); tick();
    chk("R7", {err_irq, err_flag}, 4'b0000);

    irq_en = 3'b111;
    err_ev = 3'b111; tick(); clear_in();
    tick();
    chk("R9", {err_irq, err_flag}, 4'b1111);
    mod_en = 1'b0; err_ev = 3'b111; tick();
    chk("R10", {1'b0, err_flag}, 4'b0000);
    tick(); clear_in();
    chk("R10", {err_irq, err_flag}, 4'b0000);
    mod_en = 1'b1;
    tick();

    for (int k = 0; k < 4000; k++) begin
      mod_en      = ($urandom_range(0, 19) != 0);
      for (int b = 0; b < NF; b++) err_ev[b] = ($urandom_range(0, 9) == 0);
      irq_en      = NF'($urandom);
      dbg_halt    = ($urandom_range(0, 4) == 0);
      halt_clr_ok = $urandom_range(0, 1) == 1;
      stat_rd     = ($urandom_range(0, 3) == 0);
      data_acc    = ($urandom_range(0, 3) == 0);
      tick();
      chk("R1 R2 R4 R5 R6 R7 R9 R10 random", {err_irq, err_flag}, {mi, mf});
    end

    summary();
  end
endmodule